// File: doc/BRIEF.md
# Linked-List Descriptor Walker

This block sequences one channel of a memory-to-memory mover through a chain of descriptors kept in memory. Software writes a first descriptor (source address, destination address, next pointer and control word) straight into the channel registers and pulses `start`. The walker then tells the transfer engine to move that block with a one-cycle `blk_start`. It waits for the engine's `blk_done` pulse and then inspects the next pointer. A zero pointer ends the chain, and the walker raises `chain_done` for one cycle. A non-zero pointer makes the walker read the next four-word descriptor from memory into the same registers and start another block.

Memory reads use two valid/ready channels and keep at most one read in flight. A request stays valid, with its address held steady, until `rd_req_ready` is seen high at a clock edge. A response is taken only at an edge where both `rd_rsp_valid` and `rd_rsp_ready` are high. The walker raises `rd_rsp_ready` only while it waits for the answer to a request it has already issued. A response with `rd_rsp_err` set ends the chain at once and sets `chain_err`, which stays set until the next accepted `start`. Block size, burst splitting and channel configuration belong to the transfer engine, which reads them from `cur_ctrl` and its own settings.

Top module: `llist_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `rd_req_valid`, `rd_rsp_ready`, `blk_start`, `chain_done` and `chain_err` are all low.
- R2: A `start` pulse while idle copies the four `init_*` inputs directly into `cur_src`, `cur_dst`, `cur_next` and `cur_ctrl`. No memory read is made for them. `blk_start` is high for exactly the one cycle after that edge.
- R3: No read request is issued between a `blk_start` and the matching `blk_done`.
- R4: A descriptor fetch from pointer P reads the addresses (P with bits 1:0 cleared) +0, +4, +8 and +12, in that order. Every request address has bits 1:0 equal to zero.
- R5: The responses to those four reads land in `cur_src`, `cur_dst`, `cur_next` and `cur_ctrl`, in that order. `blk_start` then pulses for one cycle, in the cycle after the fourth response is accepted.
- R6: When `blk_done` arrives and `cur_next` is zero, no read is issued. `chain_done` is high for exactly one cycle, in the cycle after that edge, and the walker returns to idle.
- R7: If `init_next` is zero, the walker runs a single block and makes no memory reads.
- R8: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays valid and `rd_req_addr` does not change on the next cycle.
- R9: A response accepted with `rd_rsp_err` high sets `chain_err` and returns the walker to idle on the next cycle, with no further `blk_start`. An accepted `start` clears `chain_err`.
- R10: `start` pulses while `busy` is high are ignored: the registers and the chain already in progress are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a chain using the `init_*` values |
| init_src | input | ADDR_W | First source address |
| init_dst | input | ADDR_W | First destination address |
| init_next | input | ADDR_W | First next-descriptor pointer (0 = single block) |
| init_ctrl | input | ADDR_W | First control word |
| blk_done | input | 1 | Transfer engine finished the current block |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted by memory |
| rd_req_addr | output | ADDR_W | Byte address of the word to read |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Walker is able to take a response |
| rd_rsp_data | input | ADDR_W | Read data word |
| rd_rsp_err | input | 1 | Read response carries an error |
| cur_src | output | ADDR_W | Current source address |
| cur_dst | output | ADDR_W | Current destination address |
| cur_next | output | ADDR_W | Current next-descriptor pointer |
| cur_ctrl | output | ADDR_W | Current control word |
| blk_start | output | 1 | One-cycle pulse: move the current block |
| chain_done | output | 1 | One-cycle pulse: last block of the chain finished |
| chain_err | output | 1 | Chain aborted by a read error |
| busy | output | 1 | Walker is not idle |

## Verification
The checker watches four things on every cycle: that a stalled request holds its address, that request addresses are word aligned, that `blk_start` and `chain_done` last a single cycle, and that an error response aborts the walker. It also checks that no request follows directly after a `blk_start`, and that the walker is quiet whenever it is idle. Only the bench scenarios can show which words land in which register and that the four reads come in order from the aligned pointer. The same holds for a zero pointer stopping the chain after exactly one completion, for a zero initial pointer producing no reads, and for a stray `start` leaving a running chain untouched.

// File: rtl/llw_pkg.sv
package llw_pkg;
  localparam int unsigned WORDS_PER_ITEM = 4;
  localparam int unsigned IDX_W = $clog2(WORDS_PER_ITEM);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KICK,
    ST_WAIT,
    ST_REQ,
    ST_RSP
  } walk_state_e;
endpackage

// File: rtl/llw_addr_gen.sv
module llw_addr_gen
  import llw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~{{(ADDR_W-2){1'b0}}, 2'b11};

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = '0;
    offset[IDX_W+1:2] = idx;
    addr = (base & ALIGN_MASK) + offset;
  end
endmodule

// File: rtl/llw_regfile.sv
module llw_regfile
  import llw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   load_init,
  input  logic [WORDS_PER_ITEM-1:0][ADDR_W-1:0]  init_words,
  input  logic                                   wr_en,
  input  logic [IDX_W-1:0]                       wr_idx,
  input  logic [ADDR_W-1:0]                      wr_data,
  output logic [WORDS_PER_ITEM-1:0][ADDR_W-1:0]  words
);
  for (genvar g = 0; g < WORDS_PER_ITEM; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[g] <= '0;
      end else if (load_init) begin
        words[g] <= init_words[g];
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        words[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/llw_fsm.sv
module llw_fsm
  import llw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              blk_done,
  input  logic [ADDR_W-1:0] cur_next,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  output logic              req_valid,
  output logic              rsp_ready,
  output logic              load_init,
  output logic              wr_en,
  output logic [IDX_W-1:0]  word_idx,
  output logic [ADDR_W-1:0] fetch_base,
  output logic              blk_start,
  output logic              chain_done,
  output logic              chain_err,
  output logic              busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS_PER_ITEM - 1);

  walk_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      word_idx   <= '0;
      fetch_base <= '0;
      chain_done <= 1'b0;
      chain_err  <= 1'b0;
    end else begin
      chain_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_KICK;
            chain_err <= 1'b0;
          end
        end
        ST_KICK: state <= ST_WAIT;
        ST_WAIT: begin
          if (blk_done) begin
            if (cur_next == '0) begin
              chain_done <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              fetch_base <= cur_next;
              word_idx   <= '0;
              state      <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (req_ready) state <= ST_RSP;
        end
        ST_RSP: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              chain_err <= 1'b1;
              state     <= ST_IDLE;
            end else if (word_idx == LAST_IDX) begin
              state <= ST_KICK;
            end else begin
              word_idx <= word_idx + 1'b1;
              state    <= ST_REQ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != ST_IDLE);
    load_init = (state == ST_IDLE) && start;
    req_valid = (state == ST_REQ);
    rsp_ready = (state == ST_RSP);
    wr_en     = rsp_ready && rsp_valid && !rsp_err;
    blk_start = (state == ST_KICK);
  end
endmodule

// File: rtl/llist_walker.sv
module llist_walker
  import llw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] init_src,
  input  logic [ADDR_W-1:0] init_dst,
  input  logic [ADDR_W-1:0] init_next,
  input  logic [ADDR_W-1:0] init_ctrl,
  input  logic              blk_done,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [ADDR_W-1:0] rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [ADDR_W-1:0] cur_next,
  output logic [ADDR_W-1:0] cur_ctrl,
  output logic              blk_start,
  output logic              chain_done,
  output logic              chain_err,
  output logic              busy
);
  logic [WORDS_PER_ITEM-1:0][ADDR_W-1:0] init_words;
  logic [WORDS_PER_ITEM-1:0][ADDR_W-1:0] words;
  logic                                  load_init;
  logic                                  wr_en;
  logic [IDX_W-1:0]                      word_idx;
  logic [ADDR_W-1:0]                     fetch_base;

  // word order in an item: source, destination, next pointer, control
  assign init_words = {init_ctrl, init_next, init_dst, init_src};
  assign cur_src    = words[0];
  assign cur_dst    = words[1];
  assign cur_next   = words[2];
  assign cur_ctrl   = words[3];

  llw_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .blk_done   (blk_done),
    .cur_next   (cur_next),
    .req_ready  (rd_req_ready),
    .rsp_valid  (rd_rsp_valid),
    .rsp_err    (rd_rsp_err),
    .req_valid  (rd_req_valid),
    .rsp_ready  (rd_rsp_ready),
    .load_init  (load_init),
    .wr_en      (wr_en),
    .word_idx   (word_idx),
    .fetch_base (fetch_base),
    .blk_start  (blk_start),
    .chain_done (chain_done),
    .chain_err  (chain_err),
    .busy       (busy)
  );

  llw_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .base (fetch_base),
    .idx  (word_idx),
    .addr (rd_req_addr)
  );

  llw_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_init  (load_init),
    .init_words (init_words),
    .wr_en      (wr_en),
    .wr_idx     (word_idx),
    .wr_data    (rd_rsp_data),
    .words      (words)
  );
endmodule

// File: rtl/llw_chk.sv
module llw_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic              rd_rsp_ready,
  input logic              rd_rsp_err,
  input logic              blk_start,
  input logic              chain_done,
  input logic              chain_err,
  input logic              busy
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R4
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr[1:0] == 2'b00);

  // R2
  kick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> !blk_start);

  // R3
  no_req_after_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> !rd_req_valid);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |=> !chain_done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> !busy && !blk_start);

  // R9
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && rd_rsp_ready && rd_rsp_err |=> chain_err && !busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !rd_rsp_ready && !blk_start);
endmodule

bind llist_walker llw_chk #(.ADDR_W(ADDR_W)) u_llw_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_rsp_valid (rd_rsp_valid),
  .rd_rsp_ready (rd_rsp_ready),
  .rd_rsp_err   (rd_rsp_err),
  .blk_start    (blk_start),
  .chain_done   (chain_done),
  .chain_err    (chain_err),
  .busy         (busy)
);

// File: tb/test_llist_walker.sv
module test_llist_walker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] init_src = '0, init_dst = '0, init_next = '0, init_ctrl = '0;
  logic          blk_done = 1'b0;
  logic          rd_req_valid, rd_rsp_ready;
  logic          rd_req_ready = 1'b0;
  logic [AW-1:0] rd_req_addr;
  logic          rd_rsp_valid = 1'b0;
  logic [AW-1:0] rd_rsp_data = '0;
  logic          rd_rsp_err = 1'b0;
  logic [AW-1:0] cur_src, cur_dst, cur_next, cur_ctrl;
  logic          blk_start, chain_done, chain_err, busy;

  llist_walker #(.ADDR_W(AW)) i_llist_walker (
    .clk(clk), .rst_n(rst_n), .start(start),
    .init_src(init_src), .init_dst(init_dst), .init_next(init_next), .init_ctrl(init_ctrl),
    .blk_done(blk_done),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_err(rd_rsp_err),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_next(cur_next), .cur_ctrl(cur_ctrl),
    .blk_start(blk_start), .chain_done(chain_done), .chain_err(chain_err), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  logic [AW-1:0]  mem [256];
  logic [AW-1:0]  err_addr = 32'hFFFF_FFF0;
  logic [AW-1:0]  exp_addr_q [$];
  logic [127:0]   exp_blk_q [$];
  int             done_cnt = 0;
  int             read_cnt = 0;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder and request scoreboard
  int            cyc = 0;
  bit            pending = 0, rsp_taken = 0, stalled = 0;
  logic [AW-1:0] pend_addr = '0, stall_addr = '0;
  always @(negedge clk) begin
    cyc++;
    if (stalled) begin
      check(rd_req_valid && rd_req_addr == stall_addr, "R8", {96'd0, rd_req_addr}, {96'd0, stall_addr});
      stalled = 0;
    end
    if (rsp_taken) begin
      rd_rsp_valid = 1'b0;
      rd_rsp_err   = 1'b0;
      rsp_taken    = 0;
    end
    if (pending && !rd_rsp_valid) begin
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = mem[pend_addr[9:2]];
      rd_rsp_err   = (pend_addr == err_addr);
      pending      = 0;
    end
    if (rd_rsp_valid && rd_rsp_ready) rsp_taken = 1;
    rd_req_ready = (cyc % 3 != 0);
    if (rd_req_valid && rd_req_ready && !pending) begin
      pending   = 1;
      pend_addr = rd_req_addr;
      read_cnt++;
      if (exp_addr_q.size() == 0) begin
        check(0, "R4 unexpected read", {96'd0, rd_req_addr}, 128'd0);
      end else begin
        logic [AW-1:0] e;
        e = exp_addr_q.pop_front();
        check(rd_req_addr == e, "R4", {96'd0, rd_req_addr}, {96'd0, e});
      end
    end else if (rd_req_valid && !rd_req_ready) begin
      stalled    = 1;
      stall_addr = rd_req_addr;
    end
  end

  // transfer engine model and block scoreboard
  bit blk_out = 0;
  int blk_cnt = 0;
  always @(negedge clk) begin
    if (chain_done) done_cnt++;
    if (rd_req_valid && blk_out) check(0, "R3 read during block", 128'd1, 128'd0);
    if (blk_done) begin
      blk_done = 1'b0;
    end else if (blk_out) begin
      if (blk_cnt == 0) begin
        blk_done = 1'b1;
        blk_out  = 0;
      end else begin
        blk_cnt--;
      end
    end
    if (blk_start) begin
      logic [127:0] act;
      act = {cur_src, cur_dst, cur_next, cur_ctrl};
      if (exp_blk_q.size() == 0) begin
        check(0, "R5 unexpected block", act, 128'd0);
      end else begin
        logic [127:0] e;
        e = exp_blk_q.pop_front();
        check(act == e, "R5 block registers", act, e);
      end
      blk_out = 1;
      blk_cnt = 2;
    end
  end

  task automatic drive_start(input logic [AW-1:0] s, d, n, c);
    @(negedge clk);
    init_src = s; init_dst = d; init_next = n; init_ctrl = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic put_item(input logic [AW-1:0] at, s, d, n, c);
    mem[at[9:2]]     = s;
    mem[at[9:2] + 1] = d;
    mem[at[9:2] + 2] = n;
    mem[at[9:2] + 3] = c;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int d0, r0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + i;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !rd_req_valid && !rd_rsp_ready && !blk_start && !chain_done && !chain_err,
          "R1 reset outputs", {122'd0, busy, rd_req_valid, rd_rsp_ready, blk_start, chain_done, chain_err}, 128'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy, "R1 idle after release", {127'd0, busy}, 128'd0);

    // R2 / R7: single block, zero initial pointer
    d0 = done_cnt; r0 = read_cnt;
    exp_blk_q.push_back({32'h1000_0000, 32'h2000_0000, 32'h0, 32'h0000_00AA});
    drive_start(32'h1000_0000, 32'h2000_0000, 32'h0, 32'h0000_00AA);
    check(blk_start && cur_src == 32'h1000_0000 && cur_ctrl == 32'h0000_00AA, "R2 direct load",
          {63'd0, blk_start, cur_src, cur_ctrl}, {63'd0, 1'b1, 32'h1000_0000, 32'h0000_00AA});
    wait_idle();
    check(done_cnt - d0 == 1, "R6 single completion", 128'(done_cnt - d0), 128'd1);
    check(read_cnt == r0, "R7 no reads", 128'(read_cnt - r0), 128'd0);

    // R4 / R5 / R6 / R10: three-block chain, unaligned first pointer
    put_item(32'h100, 32'hA1, 32'hB1, 32'h200, 32'hC1);
    put_item(32'h200, 32'hA2, 32'hB2, 32'h0, 32'hC2);
    d0 = done_cnt;
    exp_blk_q.push_back({32'hA0, 32'hB0, 32'h103, 32'hC0});
    exp_blk_q.push_back({32'hA1, 32'hB1, 32'h200, 32'hC1});
    exp_blk_q.push_back({32'hA2, 32'hB2, 32'h0, 32'hC2});
    for (int i = 0; i < 4; i++) exp_addr_q.push_back(32'h100 + 4 * i);
    for (int i = 0; i < 4; i++) exp_addr_q.push_back(32'h200 + 4 * i);
    drive_start(32'hA0, 32'hB0, 32'h103, 32'hC0);
    // R10 stray start while the first block runs
    drive_start(32'h55, 32'h66, 32'h0, 32'h77);
    check(cur_src == 32'hA0 && cur_next == 32'h103, "R10 stray start ignored",
          {64'd0, cur_src, cur_next}, {64'd0, 32'hA0, 32'h103});
    wait_idle();
    check(exp_addr_q.size() == 0, "R4 all reads made", 128'(exp_addr_q.size()), 128'd0);
    check(exp_blk_q.size() == 0, "R5 all blocks started", 128'(exp_blk_q.size()), 128'd0);
    check(done_cnt - d0 == 1, "R6 chain completion once", 128'(done_cnt - d0), 128'd1);
    check(!chain_err, "R6 no error", {127'd0, chain_err}, 128'd0);

    // R9: error on the third word of a fetched item
    put_item(32'h300, 32'hA3, 32'hB3, 32'h0, 32'hC3);
    err_addr = 32'h308;
    d0 = done_cnt;
    exp_blk_q.push_back({32'hA4, 32'hB4, 32'h300, 32'hC4});
    for (int i = 0; i < 3; i++) exp_addr_q.push_back(32'h300 + 4 * i);
    drive_start(32'hA4, 32'hB4, 32'h300, 32'hC4);
    wait_idle();
    check(chain_err && !busy, "R9 abort on error", {126'd0, chain_err, busy}, {126'd0, 2'b10});
    check(done_cnt == d0, "R9 no completion", 128'(done_cnt - d0), 128'd0);
    check(exp_addr_q.size() == 0 && exp_blk_q.size() == 0, "R9 reads and blocks",
          128'(exp_addr_q.size() + exp_blk_q.size()), 128'd0);
    err_addr = 32'hFFFF_FFF0;

    // R9: start clears error
    exp_blk_q.push_back({32'hA5, 32'hB5, 32'h0, 32'hC5});
    drive_start(32'hA5, 32'hB5, 32'h0, 32'hC5);
    check(!chain_err, "R9 cleared by start", {127'd0, chain_err}, 128'd0);
    wait_idle();
    check(exp_blk_q.size() == 0, "R2 block after restart", 128'(exp_blk_q.size()), 128'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule